// File: doc/BRIEF.md
# Dual-Mode Timer with Shared High Register

This block is a timer/counter with two modes, picked by a control bit. In narrow mode the low byte counts up and is compared with a period value. When the two are equal, the low byte clears and the period restarts. In wide mode the low and high bytes form one 16-bit up-counter that raises an event when it wraps. Before the count stage sits a power-of-two prescaler. After it sits a postscaler, which turns every N+1 events into one output pulse and sets a sticky interrupt flag.

One register serves as the high register. In narrow mode it is the period buffer, and a new period takes effect only at a period boundary. In wide mode it is a latch that makes 16-bit accesses atomic. Reading the low byte freezes the live high byte into the latch. Writing the low byte loads the latch into the live high byte. Software reaches the block through a four-address byte bus with combinational read data. The count source is either every clock or an external tick strobe.

Top module: `dmode_timer`

## Requirements
- R1: After reset all four registers read 0x00, and `pulse_o` and `irq_o` are low. Address 0 is the count low byte and address 1 is the high buffer. Address 2 is control 0: bit 0 run, bit 1 wide mode, bit 2 external source, bits 7:4 postscale N. Address 3 is control 1: bits 3:0 prescale exponent E, bit 6 interrupt enable, bit 7 flag.
- R2: In narrow mode each prescaled count either increments the low byte or, when the low byte equals the live period, clears it and raises an event. Events are therefore spaced (P+1) prescaled counts apart.
- R3: A write to address 1 changes only the buffer. In narrow mode the buffer becomes the live period at the next match, so the period in force does not change mid-count.
- R4: In wide mode the 16-bit count increments on each prescaled count and raises an event when it wraps from 0xFFFF to 0x0000.
- R5: In wide mode a read of address 0 copies the live high byte into the buffer in the same cycle, so a later read of address 1 returns the high byte as it stood at the low-byte read.
- R6: A write to address 0 loads the buffer into the live high byte in the same cycle.
- R7: Counting happens only while run is set. The source is the clock when bit 2 is 0 and `ext_tick_i` strobes when bit 2 is 1. The prescaler passes one of every 2^E source ticks, for E from 0 to 15.
- R8: One postscaled event, which sets the flag and pulses the output, occurs for every N+1 count events.
- R9: `pulse_o` is high for exactly one clock per postscaled event. The period from one pulse to the next is 2^E*(P+1)*(N+1) clocks with the clock source.
- R10: The flag stays set until a write to address 3 with bit 7 = 0. Writing bit 7 = 1 leaves it unchanged. `irq_o` is the flag gated by bit 6.
- R11: A write to address 0 or 1 clears both the prescaler and the postscaler. A write to address 2 clears the postscaler, and a write to address 3 clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (triggers wide-mode snapshot) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| ext_tick_i | input | 1 | External count strobe, one tick per high cycle |
| pulse_o | output | 1 | One-cycle postscaled event pulse |
| irq_o | output | 1 | Flag gated by interrupt enable |

## Verification
The bench sweeps prescale, period and postscale combinations, including the 2^15 prescale extreme, and compares the pulse spacing with the closed-form product. An off-by-one in the match compare or the postscaler would show up as an interval one factor too long or too short. External-tick runs check a period rewrite that must wait for the next match, and a high read that must return the frozen byte after the counter has moved on. A design that applied the buffer immediately, or read the live high byte, would return the new value too early. They also check counter clears on register writes, which a design missing them would show as an early count or an early flag.

// File: rtl/dmode_timer_pkg.sv
package dmode_timer_pkg;
  typedef enum logic [1:0] {
    REG_CNT_LO = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CTL0   = 2'd2,
    REG_CTL1   = 2'd3
  } reg_addr_e;

  localparam int unsigned C0_RUN  = 0;
  localparam int unsigned C0_WIDE = 1;
  localparam int unsigned C0_SRC  = 2;
  localparam int unsigned C0_POST = 4;
  localparam int unsigned C1_EXP  = 0;
  localparam int unsigned C1_IEN  = 6;
  localparam int unsigned C1_FLAG = 7;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned EXP_W = 4,
  localparam int unsigned CNT_W = (1 << EXP_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             term;

  assign mask   = ~({CNT_W{1'b1}} << exp_i);
  assign term   = (cnt_q >= mask);
  assign tick_o = tick_i && term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= term ? '0 : cnt_q + 1'b1;
  end

  assert_pre_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= mask);
endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
  parameter int unsigned PS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            ev_i,
  input  logic [PS_W-1:0] n_i,
  output logic            fire_o
);
  logic [PS_W-1:0] cnt_q;

  assign fire_o = ev_i && (cnt_q == n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (ev_i)  cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
  end

  assert_post_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= n_i);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          tick_i,
  input  logic          lo_wr_i,
  input  logic          hi_wr_i,
  input  logic          lo_rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] buf_o,
  output logic          event_o
);
  logic [DW-1:0] lo_q, hi_q, buf_q;
  logic          match8, wrap16;

  assign match8  = (lo_q == hi_q);
  assign wrap16  = ({hi_q, lo_q} == {(2*DW){1'b1}});
  assign event_o = tick_i && !lo_wr_i && (wide_i ? wrap16 : match8);
  assign lo_o    = lo_q;
  assign buf_o   = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (lo_wr_i) begin
      lo_q <= wdata_i;
      hi_q <= buf_q;
    end else if (tick_i) begin
      if (wide_i) begin
        {hi_q, lo_q} <= {hi_q, lo_q} + 1'b1;
      end else if (match8) begin
        lo_q <= '0;
        hi_q <= buf_q;   // staged period becomes live at the boundary
      end else begin
        lo_q <= lo_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 buf_q <= '0;
    else if (hi_wr_i)            buf_q <= wdata_i;
    else if (lo_rd_i && wide_i)  buf_q <= hi_q;
  end

  assert_narrow_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wide_i && !lo_wr_i && lo_q == hi_q) |=> (lo_q == '0));

  assert_wide_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wide_i && !lo_wr_i && {hi_q, lo_q} == {(2*DW){1'b1}})
      |=> ({hi_q, lo_q} == '0));

  assert_snapshot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_rd_i && wide_i && !hi_wr_i) |=> (buf_q == $past(hi_q)));

  assert_lo_write_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i |=> (hi_q == $past(buf_q)));
endmodule

// File: rtl/dmode_timer.sv
module dmode_timer
  import dmode_timer_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned EXP_W = 4,
  parameter int unsigned PS_W  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ext_tick_i,
  output logic          pulse_o,
  output logic          irq_o
);
  logic [DW-1:0] ctl0_q;
  logic [DW-2:0] ctl1_q;
  logic          flag_q, pulse_q;
  logic          wr_lo, wr_hi, wr_c0, wr_c1, rd_lo;
  logic          src_tick, pre_tick, cnt_ev, fire;
  logic [DW-1:0] lo_val, buf_val;

  assign wr_lo = wr_i && (addr_i == REG_CNT_LO);
  assign wr_hi = wr_i && (addr_i == REG_CNT_HI);
  assign wr_c0 = wr_i && (addr_i == REG_CTL0);
  assign wr_c1 = wr_i && (addr_i == REG_CTL1);
  assign rd_lo = rd_i && !wr_i && (addr_i == REG_CNT_LO);

  assign src_tick = ctl0_q[C0_RUN] && (ctl0_q[C0_SRC] ? ext_tick_i : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl0_q <= '0;
      ctl1_q <= '0;
    end else begin
      if (wr_c0) ctl0_q <= wdata_i;
      if (wr_c1) ctl1_q <= wdata_i[DW-2:0];
    end
  end

  tmr_prescaler #(.EXP_W(EXP_W)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_lo || wr_hi || wr_c1),
    .tick_i (src_tick),
    .exp_i  (ctl1_q[C1_EXP +: EXP_W]),
    .tick_o (pre_tick)
  );

  tmr_count #(.DW(DW)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wide_i  (ctl0_q[C0_WIDE]),
    .tick_i  (pre_tick),
    .lo_wr_i (wr_lo),
    .hi_wr_i (wr_hi),
    .lo_rd_i (rd_lo),
    .wdata_i (wdata_i),
    .lo_o    (lo_val),
    .buf_o   (buf_val),
    .event_o (cnt_ev)
  );

  tmr_postscaler #(.PS_W(PS_W)) i_post (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_lo || wr_hi || wr_c0),
    .ev_i   (cnt_ev),
    .n_i    (ctl0_q[C0_POST +: PS_W]),
    .fire_o (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (fire)                                flag_q <= 1'b1;
      else if (wr_c1 && !wdata_i[C1_FLAG])     flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_CNT_LO: rdata_o = lo_val;
      REG_CNT_HI: rdata_o = buf_val;
      REG_CTL0:   rdata_o = ctl0_q;
      default:    rdata_o = {flag_q, ctl1_q};
    endcase
  end

  assign pulse_o = pulse_q;
  assign irq_o   = flag_q && ctl1_q[C1_IEN];

  assert_pulse_sets_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> flag_q);

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !wr_c1) |=> flag_q);
endmodule

// File: tb/test_dmode_timer.sv
module test_dmode_timer;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ext_tick_i = 1'b0;
  logic       pulse_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  dmode_timer i_dmode_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ext_tick_i(ext_tick_i),
    .pulse_o(pulse_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1; #1 v = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); ext_tick_i = 1'b1;
      @(negedge clk_i); ext_tick_i = 1'b0;
    end
  endtask

  task automatic wait_pulse(input int lim, output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!pulse_o && n < lim);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, n, exp_iv;
    int pe[2] = '{0, 2};
    int pp[3] = '{1, 4, 9};
    int pn[2] = '{0, 3};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); check("R1 reg reset", v, 0); end
    check("R1 pulse reset", pulse_o, 0);
    check("R1 irq reset", irq_o, 0);

    // R2 R8 R9 interval sweep, clock source
    foreach (pe[i]) foreach (pp[j]) foreach (pn[k]) begin
      wr(2, 8'h00);
      wr(3, pe[i][7:0] | 8'h40);
      wr(1, pp[j][7:0]);
      wr(0, 8'h00);
      wr(2, 8'h01 | (pn[k][7:0] << 4));
      exp_iv = (1 << pe[i]) * (pp[j] + 1) * (pn[k] + 1);
      wait_pulse(2000, n);
      @(negedge clk_i);
      check("R9 pulse one cycle", pulse_o, 0);
      wait_pulse(2000, n);
      check("R2 R8 R9 interval", n + 1, exp_iv);
    end

    // R10 flag and irq
    wr(2, 8'h00);
    rd(3, v); check("R10 flag set", v[7], 1);
    check("R10 irq when enabled", irq_o, 1);
    wr(3, 8'h80);
    check("R10 irq masked", irq_o, 0);
    rd(3, v); check("R10 write 1 keeps flag", v[7], 1);
    wr(3, 8'h40);
    rd(3, v); check("R10 flag cleared", v[7], 0);
    check("R10 irq after clear", irq_o, 0);

    // R7 largest prescale
    wr(3, 8'h0F);
    wr(1, 8'h00);
    wr(0, 8'h00);
    wr(2, 8'h01);
    wait_pulse(40000, n);
    wait_pulse(40000, n);
    check("R7 prescale 2^15 interval", n, 32768);
    wr(2, 8'h00);

    // R3 period buffered until match, external source
    wr(3, 8'h00);
    wr(2, 8'h05);
    wr(1, 8'h03);
    wr(0, 8'h00);
    wr(1, 8'h07);
    strobe(3);
    rd(0, v); check("R3 old period counting", v, 3);
    strobe(1);
    check("R2 match pulse", pulse_o, 1);
    rd(0, v); check("R2 low cleared", v, 0);
    strobe(4);
    rd(0, v); check("R3 new period after match", v, 4);
    repeat (5) @(negedge clk_i);
    rd(0, v); check("R7 external source idle", v, 4);
    rd(1, v); check("R3 narrow high reads buffer", v, 7);

    // R7 R11 prescaler clear
    wr(3, 8'h02);
    wr(1, 8'd200);
    wr(0, 8'd5);
    strobe(3);
    rd(0, v); check("R7 div4 holds", v, 5);
    wr(0, 8'd5);
    strobe(1);
    rd(0, v); check("R11 prescaler cleared", v, 5);
    strobe(3);
    rd(0, v); check("R7 div4 count", v, 6);

    // R8 R11 postscaler clear
    wr(3, 8'h00);
    wr(2, 8'h15);
    wr(1, 8'h00);
    wr(0, 8'h00);
    strobe(1);
    rd(3, v); check("R8 first event no flag", v[7], 0);
    wr(0, 8'h00);
    strobe(1);
    rd(3, v); check("R11 postscaler cleared", v[7], 0);
    strobe(1);
    rd(3, v); check("R8 second event flags", v[7], 1);

    // R4 wide overflow
    wr(3, 8'h00);
    wr(2, 8'h07);
    wr(1, 8'hFF);
    wr(0, 8'hFD);
    strobe(2);
    rd(3, v); check("R4 no flag before wrap", v[7], 0);
    strobe(1);
    check("R4 wrap pulse", pulse_o, 1);
    rd(0, v); check("R4 low after wrap", v, 0);
    rd(1, v); check("R4 high after wrap", v, 0);

    // R5 R6 atomic high access
    wr(1, 8'h12);
    wr(0, 8'hFF);
    rd(0, v); check("R6 low written", v, 8'hFF);
    strobe(1);
    rd(1, v); check("R5 snapshot survives carry", v, 8'h12);
    rd(0, v); check("R4 carry low", v, 0);
    rd(1, v); check("R5 fresh snapshot", v, 8'h13);
    wr(1, 8'h55);
    strobe(1);
    rd(0, v); check("R3 wide buffer write not live", v, 1);
    rd(1, v); check("R3 R5 live high unchanged", v, 8'h13);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule